// File: doc/BRIEF.md
# Dual Wiper Serial Loader

This block is the device-side serial port of a two-channel, 256-step digital potentiometer. A host drives a three-wire serial stream: an active-low select, a serial clock and a data line. The block keeps one 8-bit wiper code per channel. Each complete frame writes exactly one channel, and the write takes effect when the select line is released.

All logic runs on a system clock. The three serial pins pass through two-flop synchronizers, and edges are found by comparing successive synchronized samples, so the system clock must run at least four times faster than the serial clock. Within one select-low window, data bits are taken on rising serial clock edges, most significant bit first. Only the last nine bits received count. The first of those nine picks the channel and the remaining eight give the code. Frames that carry fewer than nine bits are dropped.

The outputs are the two wiper codes and a one-cycle update pulse per channel. The analog side reads these outputs.

Top module: `dual_wiper_loader`

## Requirements
- R1: After reset both wiper codes equal midscale 0x80 and both update pulses are low.
- R2: A frame of exactly nine bits, sent most significant first, is decoded as follows. The first bit is the channel select (0 for wiper A, 1 for wiper B) and the next eight bits are the code. The code is written into the selected wiper after the select line goes high.
- R3: A load leaves the wiper that was not selected, and its update pulse, unchanged.
- R4: When a frame carries more than nine bits, only the last nine received are used. The earlier bits are discarded.
- R5: A frame with fewer than nine bits changes neither wiper and raises no update pulse.
- R6: Each valid load raises the selected channel's update pulse for exactly one system clock cycle, in the same cycle in which the new code first appears. At most one update pulse is high at any time.
- R7: Serial clock edges that occur while the select line is high do not shift data, do not count bits, and do not change either wiper.
- R8: Every code from 0x00 to 0xFF can be stored in either wiper, including both ends of the range.
- R9: The bit count restarts at each falling edge of the select line. Two short frames that together reach nine bits still load nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| spi_cs_n | input | 1 | Serial select, active low, asynchronous to clk |
| spi_sclk | input | 1 | Serial clock; data is taken on its rising edge |
| spi_sdi | input | 1 | Serial data in |
| wiper_a | output | 8 | Wiper A code |
| wiper_b | output | 8 | Wiper B code |
| upd_a | output | 1 | One-cycle pulse when wiper A is written |
| upd_b | output | 1 | One-cycle pulse when wiper B is written |

## Verification
The assertions check several properties on every cycle:
- The bit counter never passes nine and clears on a select fall.
- The shift register stays still while the select line is high.
- A wiper changes only together with its own update pulse, and that pulse is single-cycle and exclusive.
- A select release after a short frame produces no pulse.

Other properties depend on frame content, and only the bench scenarios can show them:
- Correct decoding of the channel bit and the code bits.
- Keeping the last nine bits of an over-long frame.
- Discarding split short frames.
- Reaching both ends of the code range.

The bench compares both wipers and per-channel pulse counts against its own model after every frame.

// File: rtl/wiper_loader_pkg.sv
package wiper_loader_pkg;
  localparam int CODE_W = 8;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = $clog2(NUM_CH);
  localparam int WORD_W = ADDR_W + CODE_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int SYNC_STAGES = 2;

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    code_t             code;
  } word_t;

  localparam code_t MID_CODE = code_t'(1) << (CODE_W - 1);
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = din;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import wiper_loader_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_n_s,
  input  logic  sclk_s,
  input  logic  sdi_s,
  output logic  cs_rise,
  output logic  word_full,
  output word_t word
);
  logic              cs_prev_q, sclk_prev_q;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cs_fall, sclk_rise, shift_en;

  assign cs_rise   =  cs_n_s & ~cs_prev_q;
  assign cs_fall   = ~cs_n_s &  cs_prev_q;
  assign sclk_rise =  sclk_s & ~sclk_prev_q;
  assign shift_en  =  sclk_rise & ~cs_n_s;

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cs_fall ? '0 : cnt_q;
    if (shift_en) begin
      shreg_d = {shreg_q[WORD_W-2:0], sdi_s};
      if (cnt_d != CNT_W'(WORD_W)) cnt_d = cnt_d + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
      shreg_q     <= '0;
      cnt_q       <= '0;
    end else begin
      cs_prev_q   <= cs_n_s;
      sclk_prev_q <= sclk_s;
      if (shift_en) shreg_q <= shreg_d;
      if (shift_en || cs_fall) cnt_q <= cnt_d;
    end
  end

  assign word_full = (cnt_q == CNT_W'(WORD_W));
  assign word      = word_t'(shreg_q);

  p_cnt_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORD_W));
  p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !sclk_rise) |=> (cnt_q == '0));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> ($stable(shreg_q) && $stable(cnt_q)));
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wiper_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  word_t             word,
  output code_t             wiper [NUM_CH],
  output logic [NUM_CH-1:0] strobe
);
  code_t             wiper_q [NUM_CH];
  logic [NUM_CH-1:0] strobe_q, hit;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign hit[i] = load_en && (word.addr == ADDR_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wiper_q[i]  <= MID_CODE;
          strobe_q[i] <= 1'b0;
        end else begin
          strobe_q[i] <= hit[i];
          if (hit[i]) wiper_q[i] <= word.code;
        end
      end

      assign wiper[i] = wiper_q[i];

      p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_q[i] |-> $stable(wiper_q[i]));
      p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q[i] |=> !strobe_q[i]);
    end
  endgenerate

  assign strobe = strobe_q;

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe_q));
endmodule

// File: rtl/dual_wiper_loader.sv
module dual_wiper_loader
  import wiper_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_sdi,
  output logic [CODE_W-1:0] wiper_a,
  output logic [CODE_W-1:0] wiper_b,
  output logic              upd_a,
  output logic              upd_b
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [2:0]        pins_s;
  logic              cs_rise, word_full, load_en;
  word_t             word;
  code_t             wiper [NUM_CH];
  logic [NUM_CH-1:0] strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   ({spi_cs_n, spi_sclk, spi_sdi}),
    .dout  (pins_s)
  );

  frame_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cs_n_s    (pins_s[2]),
    .sclk_s    (pins_s[1]),
    .sdi_s     (pins_s[0]),
    .cs_rise   (cs_rise),
    .word_full (word_full),
    .word      (word)
  );

  assign load_en = cs_rise & word_full;

  wiper_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_en (load_en),
    .word    (word),
    .wiper   (wiper),
    .strobe  (strobe)
  );

  assign wiper_a = wiper[0];
  assign wiper_b = wiper[1];
  assign upd_a   = strobe[0];
  assign upd_b   = strobe[1];

  p_short_drop_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cs_rise && !word_full) |=> (strobe == '0));
  p_load_pulse_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cs_rise && word_full) |=> ($countones(strobe) == 1));
endmodule

// File: tb/dual_wiper_loader_tb.sv
module dual_wiper_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SC = 4;

  logic       clk = 1'b0;
  logic       rst_n, spi_cs_n, spi_sclk, spi_sdi;
  logic [7:0] wiper_a, wiper_b;
  logic       upd_a, upd_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_w [2];
  int exp_p [2];
  int pulses [2];
  int hi_cyc [2];
  logic prev_a = 1'b0, prev_b = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_wiper_loader u_dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_sdi(spi_sdi), .wiper_a(wiper_a), .wiper_b(wiper_b),
    .upd_a(upd_a), .upd_b(upd_b)
  );

  always @(negedge clk) begin
    if (upd_a) hi_cyc[0]++;
    if (upd_b) hi_cyc[1]++;
    if (upd_a && !prev_a) pulses[0]++;
    if (upd_b && !prev_b) pulses[1]++;
    if (upd_a && wiper_a != exp_pending(0)) ; // value checked after frame
    prev_a = upd_a;
    prev_b = upd_b;
  end

  function automatic logic [7:0] exp_pending(input int ch);
    return exp_w[ch];
  endfunction

  function automatic bit frame_loads(input int n);
    return n >= 9;
  endfunction

  function automatic logic [8:0] last_word(input logic [31:0] v);
    return v[8:0];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " wiper_a"}, wiper_a, exp_w[0]);
    chk({req, " wiper_b"}, wiper_b, exp_w[1]);
    chk({req, " pulses_a"}, pulses[0], exp_p[0]);
    chk({req, " pulses_b"}, pulses[1], exp_p[1]);
    chk({req, " R6 width_a"}, hi_cyc[0], pulses[0]);
    chk({req, " R6 width_b"}, hi_cyc[1], pulses[1]);
  endtask

  task automatic send_bits(input int n, input logic [31:0] v);
    spi_cs_n = 1'b0;
    repeat (SC) @(negedge clk);
    for (int k = n - 1; k >= 0; k--) begin
      spi_sdi = v[k];
      repeat (SC) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (SC) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (SC) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic frame(input int n, input logic [31:0] v, input string req);
    logic [8:0] w;
    send_bits(n, v);
    if (frame_loads(n)) begin
      w = last_word(v);
      exp_w[w[8]] = w[7:0];
      exp_p[w[8]]++;
    end
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    exp_w[0] = 8'h80; exp_w[1] = 8'h80;
    exp_p[0] = 0; exp_p[1] = 0;
    pulses[0] = 0; pulses[1] = 0;
    hi_cyc[0] = 0; hi_cyc[1] = 0;
    rst_n = 1'b0; spi_cs_n = 1'b1; spi_sclk = 1'b0; spi_sdi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk("R1 wiper_a", wiper_a, 8'h80);
    chk("R1 wiper_b", wiper_b, 8'h80);
    chk("R1 upd", {upd_a, upd_b}, 0);

    // R2 / R3 exact frames to each channel
    frame(9, {23'd0, 1'b0, 8'h3C}, "R2 ch A");
    frame(9, {23'd0, 1'b1, 8'hA5}, "R2 R3 ch B");
    frame(9, {23'd0, 1'b0, 8'h5A}, "R3 ch A only");
    // R8 range ends
    frame(9, {23'd0, 1'b0, 8'h00}, "R8 zero A");
    frame(9, {23'd0, 1'b1, 8'hFF}, "R8 full B");
    frame(9, {23'd0, 1'b1, 8'h00}, "R8 zero B");
    frame(9, {23'd0, 1'b0, 8'hFF}, "R8 full A");
    // R4 long frames: leading bits discarded
    frame(13, {19'd0, 4'b1111, 1'b0, 8'h12}, "R4 long A");
    frame(12, {20'd0, 3'b000, 1'b1, 8'h34}, "R4 long B");
    // R5 short frames
    frame(8, {24'd0, 8'hFF}, "R5 short 8");
    frame(1, 32'd1, "R5 short 1");
    // R9 split frames totaling nine bits
    frame(4, 32'hF, "R9 split first");
    frame(5, 32'h1F, "R9 split second");
    // R7 clocks while select high
    for (int k = 0; k < 12; k++) begin
      spi_sdi = 1'($urandom);
      repeat (SC) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (SC) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (12) @(negedge clk);
    check_all("R7 idle clocks");
    frame(9, {23'd0, 1'b1, 8'h77}, "R7 R2 after idle");

    // random mix
    for (int f = 0; f < 40; f++) begin
      frame($urandom_range(14, 3), $urandom, "R2 R4 R5 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule